// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog timer that runs from the oscillator clock. A fixed pre-divider of 512 feeds a selectable second stage (divide by 1 to 64). The result steps an 8-bit counter. When the counter wraps, the block drives a chip reset request for a fixed 512 oscillator cycles. Firmware keeps the chip alive by writing a two-byte service key into a separate key port. The key is 8'h55 followed directly by 8'hAA, and it returns the counter to zero.

A single control register sets the prescale, holds the disable bit and reports whether the last reset came from the watchdog. Every write to that register must carry the check pattern 3'b101 in bits 5:3. A write with any other pattern resets the chip at once. The disable bit only follows a write while the external override input is high.

While its own reset request is active, the block treats itself as reset: it comes back enabled, with prescale 000 and the status flag set. Only the external active-low reset clears the flag through reset.

Top module: `wdog_keyed`

## Requirements
- R1: After the external reset `rstN`, the control readback is 16'h0000 (flag clear, enabled, prescale 000) and `wdRstOut` is low.
- R2: A control write whose bits 5:3 differ from 3'b101 raises `wdRstOut` at the clock edge that samples the write. This holds even while the watchdog is disabled.
- R3: Control bit 6 (1 = disabled, 0 = running) takes the written value only when `overrideEn` is 1. With `overrideEn` at 0 it keeps its value.
- R4: While disabled, the prescaler and counter stay at zero and no reset request comes from counting. After re-enabling, counting restarts from zero.
- R5: Control bits 2:0 select an extra divide of 2^k, with k = 0 for codes 000 and 001 and k = code-1 otherwise. Starting from zero, the request rises 2^(DIV_LOG2+k) * 2^CNT_W clock edges after counting begins.
- R6: Each reset request stays high for exactly PULSE_LEN clock cycles.
- R7: Control bit 7 is set when the watchdog raises a reset request. It is cleared by `rstN` or by a valid control write with bit 7 = 1; writing 0 leaves it. After a watchdog reset the block reads 16'h0080: enabled, prescale 000.
- R8: A key write of 8'hAA that directly follows a key write of 8'h55 clears the counter. Any other key sequence leaves the counting period unchanged.
- R9: Control readback bits 15:8 and 5:3 are always zero.
- R10: If a service clear and a counter overflow fall in the same cycle, the clear wins: no request is raised, and the next one comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Power-on / external reset, active low, asynchronous |
| overrideEn | input | 1 | Permits writes to the disable bit when 1 |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 8 | Control write data: bit 7 flag-clear, bit 6 disable, bits 5:3 check, bits 2:0 prescale |
| keyWrEn | input | 1 | Key register write strobe |
| keyWrData | input | 8 | Key byte |
| ctlRdData | output | 16 | Control register readback |
| wdRstOut | output | 1 | Chip reset request |

## Verification
Two functions can act on the same clock edge: the service key completing, and the counter overflowing. The bench tracks the position of every clock edge. It times the 8'hAA write to land on the exact edge where the counter would wrap. The design passes if the request stays low on that edge and then rises exactly one full counting period later, not sooner. The bench also checks that a broken key sequence does not move the overflow edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Largest extra divide is 2^6 = 64.
  localparam int MAX_EXTRA_LOG2 = 6;

  typedef struct packed {
    logic       holdZero;
    logic       svcClear;
    logic [2:0] preSel;
  } dpCtl_t;

  // Prescale code to log2 of the extra divide; codes 0 and 1 both mean /1.
  function automatic logic [2:0] extraLog2(input logic [2:0] sel);
    return (sel == 3'd0) ? 3'd0 : sel - 3'd1;
  endfunction
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int DIV_LOG2 = 9,
  parameter int CNT_W    = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t dpCtl,
  output logic   ovfTick
);
  localparam int PRE_W = DIV_LOG2 + MAX_EXTRA_LOG2;

  logic [PRE_W-1:0] prescQ;
  logic [PRE_W-1:0] tickMask;
  logic [CNT_W-1:0] cntQ;
  logic             tick;

  // The low DIV_LOG2+k bits all set marks one counting-clock period.
  assign tickMask = {PRE_W{1'b1}} >> (3'(MAX_EXTRA_LOG2) - extraLog2(dpCtl.preSel));
  assign tick     = ((prescQ & tickMask) == tickMask);
  assign ovfTick  = !dpCtl.holdZero && !dpCtl.svcClear && tick && (cntQ == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescQ <= '0;
      cntQ   <= '0;
    end else if (dpCtl.holdZero) begin
      prescQ <= '0;
      cntQ   <= '0;
    end else begin
      prescQ <= prescQ + PRE_W'(1);
      if (dpCtl.svcClear)
        cntQ <= '0;
      else if (tick)
        cntQ <= cntQ + CNT_W'(1);
    end
  end

  // R8 / R10: a service clear empties the counter whatever the tick does.
  assert_svc_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.svcClear && !dpCtl.holdZero) |=> (cntQ == '0));

  // R5: the counter moves only on a counting-clock tick.
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.holdZero && !dpCtl.svcClear && !tick) |=> $stable(cntQ));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          PULSE_LEN  = 512,
  parameter logic [2:0]  CHECK_CODE = 3'b101,
  parameter logic [7:0]  KEY_ARM    = 8'h55,
  parameter logic [7:0]  KEY_FIRE   = 8'hAA
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        overrideEn,
  input  logic        ctlWrEn,
  input  logic [7:0]  ctlWrData,
  input  logic        keyWrEn,
  input  logic [7:0]  keyWrData,
  input  logic        ovfTick,
  output dpCtl_t      dpCtl,
  output logic [15:0] ctlRdData,
  output logic        wdRstOut
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          flagQ, disQ, activeQ, armedQ;
  logic [2:0]    preQ;
  logic [PW-1:0] pcntQ;
  logic          checkOk, goodWr, badWr, startPulse, svcHit;

  assign checkOk    = (ctlWrData[5:3] == CHECK_CODE);
  assign goodWr     = ctlWrEn && checkOk && !activeQ;
  assign badWr      = ctlWrEn && !checkOk && !activeQ;
  assign startPulse = badWr || ovfTick;
  assign svcHit     = keyWrEn && armedQ && (keyWrData == KEY_FIRE) && !activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= 1'b0;
      disQ    <= 1'b0;
      preQ    <= 3'd0;
      armedQ  <= 1'b0;
      activeQ <= 1'b0;
      pcntQ   <= '0;
    end else if (activeQ) begin
      // The block's own request acts as a device reset.
      disQ   <= 1'b0;
      preQ   <= 3'd0;
      armedQ <= 1'b0;
      pcntQ  <= pcntQ + PW'(1);
      if (pcntQ == PW'(PULSE_LEN - 1))
        activeQ <= 1'b0;
    end else if (startPulse) begin
      activeQ <= 1'b1;
      pcntQ   <= '0;
      flagQ   <= 1'b1;
      disQ    <= 1'b0;
      preQ    <= 3'd0;
      armedQ  <= 1'b0;
    end else begin
      if (goodWr) begin
        preQ <= ctlWrData[2:0];
        if (overrideEn)
          disQ <= ctlWrData[6];
        if (ctlWrData[7])
          flagQ <= 1'b0;
      end
      if (keyWrEn)
        armedQ <= (keyWrData == KEY_ARM);
    end
  end

  assign wdRstOut       = activeQ;
  assign ctlRdData      = {8'h00, flagQ, disQ, 3'b000, preQ};
  assign dpCtl.holdZero = disQ || activeQ;
  assign dpCtl.svcClear = svcHit;
  assign dpCtl.preSel   = preQ;

  // R2: a write with a wrong check field raises the request at once.
  assert_bad_check_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && (ctlWrData[5:3] != CHECK_CODE) && !wdRstOut) |=> wdRstOut);

  // R3: without override the disable bit cannot be written.
  assert_dis_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!overrideEn && !activeQ && !startPulse) |=> $stable(disQ));

  // R4: no overflow reaches the control side while disabled.
  assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    disQ |-> !ovfTick);

  // R7: the status flag is set as the request rises.
  assert_flag_on_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRstOut) |-> ctlRdData[7]);

  // R7: the watchdog comes back enabled after its own reset.
  assert_enabled_after_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdRstOut) |-> (ctlRdData[6] == 1'b0));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int DIV_LOG2  = 9,
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        overrideEn,
  input  logic        ctlWrEn,
  input  logic [7:0]  ctlWrData,
  input  logic        keyWrEn,
  input  logic [7:0]  keyWrData,
  output logic [15:0] ctlRdData,
  output logic        wdRstOut
);
  dpCtl_t dpCtl;
  logic   ovfTick;

  wdog_ctrl #(
    .PULSE_LEN (PULSE_LEN)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .overrideEn (overrideEn),
    .ctlWrEn    (ctlWrEn),
    .ctlWrData  (ctlWrData),
    .keyWrEn    (keyWrEn),
    .keyWrData  (keyWrData),
    .ovfTick    (ovfTick),
    .dpCtl      (dpCtl),
    .ctlRdData  (ctlRdData),
    .wdRstOut   (wdRstOut)
  );

  wdog_dp #(
    .DIV_LOG2 (DIV_LOG2),
    .CNT_W    (CNT_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .ovfTick (ovfTick)
  );
endmodule

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;
  localparam int DIVL = 3;
  localparam int CW   = 4;
  localparam int PLEN = 16;
  localparam int BASE = 128; // 2^DIVL * 2^CW at divide-by-1

  // {prescale code, expected period in clock edges}
  localparam int VEC [8][2] = '{
    '{0, 128}, '{1, 128}, '{2, 256}, '{3, 512},
    '{4, 1024}, '{5, 2048}, '{6, 4096}, '{7, 8192}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        overrideEn = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [7:0]  ctlWrData = 8'h00;
  logic        keyWrEn = 1'b0;
  logic [7:0]  keyWrData = 8'h00;
  logic [15:0] ctlRdData;
  logic        wdRstOut;

  int checks = 0;
  int fails = 0;
  int edgeCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) edgeCount <= edgeCount + 1;

  wdog_keyed #(.DIV_LOG2(DIVL), .CNT_W(CW), .PULSE_LEN(PLEN)) uut (
    .clk(clk), .rstN(rstN), .overrideEn(overrideEn),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .keyWrEn(keyWrEn), .keyWrData(keyWrData),
    .ctlRdData(ctlRdData), .wdRstOut(wdRstOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [7:0] d);
    ctlWrEn = 1'b1; ctlWrData = d;
    @(posedge clk); #1;
    ctlWrEn = 1'b0;
  endtask

  task automatic keyWrite(input logic [7:0] d);
    keyWrEn = 1'b1; keyWrData = d;
    @(posedge clk); #1;
    keyWrEn = 1'b0;
  endtask

  task automatic waitEdge(input int t);
    while (edgeCount < t) begin @(posedge clk); #1; end
  endtask

  task automatic measureRise(output int e);
    e = -1;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      if (wdRstOut) begin e = edgeCount; break; end
    end
  endtask

  task automatic measurePulse(output int n);
    n = 0;
    while (wdRstOut && n < 100000) begin @(posedge clk); #1; n++; end
  endtask

  int w, r, n, highs;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 readback in reset", ctlRdData, 16'h0000);
    check("R1 request in reset", wdRstOut, 1'b0);
    rstN = 1'b1;
    #1;
    // R9: reserved and check bits read zero; R3: bit 6 ignored without override
    ctlWrite(8'h6F);
    check("R9/R3 readback", ctlRdData, 16'h0007);
    ctlWrite(8'h68);
    check("R3 disable ignored", ctlRdData, 16'h0000);
    overrideEn = 1'b1;
    ctlWrite(8'h68);
    check("R3 disable taken", ctlRdData, 16'h0040);
    // R4: quiet while disabled
    highs = 0;
    repeat (400) begin @(posedge clk); #1; if (wdRstOut) highs++; end
    check("R4 no request while off", highs, 0);
    ctlWrite(8'h28); w = edgeCount;
    measureRise(r);
    check("R4 restart from zero", r - w, BASE);
    measurePulse(n);
    check("R6 pulse length", n, PLEN);
    check("R7 flag after watchdog reset", ctlRdData, 16'h0080);
    ctlWrite(8'h28);
    check("R7 writing 0 keeps flag", ctlRdData, 16'h0080);
    ctlWrite(8'hA8);
    check("R7 writing 1 clears flag", ctlRdData, 16'h0000);

    // R5 table walk
    for (int v = 0; v < 8; v++) begin
      ctlWrite(8'h68 | 8'(VEC[v][0]));
      ctlWrite(8'h28 | 8'(VEC[v][0])); w = edgeCount;
      measureRise(r);
      check($sformatf("R5 period code %0d", VEC[v][0]), r - w, VEC[v][1]);
      measurePulse(n);
      check("R6 pulse length", n, PLEN);
      check("R7 state after watchdog reset", ctlRdData, 16'h0080);
    end

    // R2: bad check field resets even while disabled
    ctlWrite(8'hE8);
    ctlWrite(8'h40);
    check("R2 bad check raises request", wdRstOut, 1'b1);
    measurePulse(n);
    check("R7 enabled with flag after R2 reset", ctlRdData, 16'h0080);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R7 external reset clears flag", ctlRdData, 16'h0000);
    rstN = 1'b1; #1;
    ctlWrite(8'h68);

    // R8: valid service key
    ctlWrite(8'h28); w = edgeCount;
    waitEdge(w + 20); keyWrite(8'h55);
    waitEdge(w + 99); keyWrite(8'hAA);
    measureRise(r);
    check("R8 service key delays request", r - w, 224);
    measurePulse(n);
    ctlWrite(8'h68);

    // R8: broken sequence has no effect
    ctlWrite(8'h28); w = edgeCount;
    waitEdge(w + 20); keyWrite(8'h55);
    keyWrite(8'h12);
    keyWrite(8'hAA);
    measureRise(r);
    check("R8 broken key ignored", r - w, BASE);
    measurePulse(n);
    ctlWrite(8'h68);

    // R10: service clear on the overflow edge
    ctlWrite(8'h28); w = edgeCount;
    waitEdge(w + 50); keyWrite(8'h55);
    waitEdge(w + BASE - 1); keyWrite(8'hAA);
    check("R10 no request on collision edge", wdRstOut, 1'b0);
    measureRise(r);
    check("R10 next request one period later", r - w, 2 * BASE);
    measurePulse(n);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule